// File: doc/BRIEF.md
# Streaming Complex Magnitude-Squared Stage

This block sits in an AXI4-Stream pipeline and turns each complex sample into its squared magnitude. Every accepted input beat carries one complex value as two signed halves of a single word. For each beat the block squares both halves and adds the two squares. The result is the magnitude without its square root, and a later stage can take that root.

The arithmetic runs in a two-register pipeline: one register stage holds the two squares and the next holds their sum. Each stage keeps its own valid flag and moves forward only when the stage after it can take data. The output can therefore stall for any number of cycles without dropping or repeating a result. The frame-end marker of each input beat travels through the pipeline with that beat's result. No state is kept from one sample to the next.

Top module: `cplx_magsq_stream`

## Requirements
- R1: The input word is split with the real part in bits [31:16] and the imaginary part in bits [15:0]. Both parts are two's-complement signed and are sign-extended before squaring.
- R2: For every accepted input the output word is real*real + imag*imag as an unsigned 32-bit value. Two parts of -32768 give 32'h8000_0000, which is the largest possible result, and no result exceeds it.
- R3: The m_tlast value of each output beat equals the s_tlast value of the input beat that produced it.
- R4: Every accepted input yields exactly one output transfer, in acceptance order, with none lost or repeated. After draining, the number of output transfers equals the number of input transfers.
- R5: While m_tvalid is high and m_tready is low, m_tvalid stays high and m_tdata and m_tlast hold their values.
- R6: s_tready is high unless both pipeline stages are full and m_tready is low. In particular, s_tready is high whenever m_tvalid is low.
- R7: With m_tready high, a beat accepted at one clock edge shows m_tvalid low after that edge and high with its result after the next edge.
- R8: m_tstrb is all ones (4'hF).
- R9: rst_n is a synchronous active-low reset. It empties both stages, and m_tvalid is low while reset is held and in the cycle after it is released, even if s_tvalid is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| s_tdata | input | 32 | Input sample: real part in the high half, imaginary part in the low half |
| s_tvalid | input | 1 | Input beat valid |
| s_tlast | input | 1 | Input beat ends a frame |
| s_tready | output | 1 | Stage can take an input beat |
| m_tdata | output | 32 | Squared magnitude of the sample |
| m_tvalid | output | 1 | Output beat valid |
| m_tlast | output | 1 | Output beat ends a frame |
| m_tstrb | output | 4 | Byte strobes, always all ones |
| m_tready | input | 1 | Downstream can take the output beat |

## Verification
The bench builds the block with its default part width of 16 bits. At that width the two most negative parts together give exactly 2^31, so the worst case of the sum and both sign extensions can be checked against literal values. Random sources, a held-low m_tready lasting more than three hundred cycles, coin-flip m_tready patterns and a reset in the middle of a stream bring every fill level of both stages within reach: empty, half full, and full with the input blocked. A queue model checks each beat for loss, repetition, order, frame marker and value.

// File: rtl/magsq_pkg.sv
package magsq_pkg;

  // Default width of one signed component of a complex sample.
  localparam int unsigned MSQ_PART_W = 16;

  // Result width: a squared part needs twice the part width, and the sum of
  // two squares of two's-complement parts never exceeds 2^(2*PART_W-1).
  function automatic int unsigned msq_res_w(input int unsigned part_w);
    return 2 * part_w;
  endfunction

endpackage

// File: rtl/magsq_square_stage.sv
module magsq_square_stage #(
  parameter int unsigned PART_W = magsq_pkg::MSQ_PART_W
) (
  input  logic                                                clk,
  input  logic                                                rst_n,
  input  logic                                                in_valid,
  input  logic [2*PART_W-1:0]                                 in_data,
  input  logic                                                in_last,
  input  logic                                                dn_ready,
  output logic                                                in_ready,
  output logic                                                out_valid,
  output logic                                                out_last,
  output logic [1:0][magsq_pkg::msq_res_w(PART_W)-1:0]        sq_pair
);

  localparam int unsigned SQ_W = magsq_pkg::msq_res_w(PART_W);

  // Sign-extend one part and square it; the product is never negative.
  function automatic logic [SQ_W-1:0] square_part(input logic [PART_W-1:0] p);
    logic signed [SQ_W-1:0] wide;
    wide = {{PART_W{p[PART_W-1]}}, p};
    return $unsigned(wide * wide);
  endfunction

  logic load;

  // The stage takes a beat when empty or when its content moves on now.
  assign in_ready = !out_valid || dn_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)        out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (load) out_last <= in_last;
  end

  // Index 1 is the real part (high half), index 0 the imaginary part.
  for (genvar g = 0; g < 2; g++) begin : g_part
    logic [SQ_W-1:0] sq_q;
    always_ff @(posedge clk) begin
      if (load) sq_q <= square_part(in_data[g*PART_W +: PART_W]);
    end
    assign sq_pair[g] = sq_q;
  end

endmodule

// File: rtl/magsq_sum_stage.sv
module magsq_sum_stage #(
  parameter int unsigned SQ_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [1:0][SQ_W-1:0] sq_pair,
  input  logic                 in_last,
  input  logic                 out_ready,
  output logic                 in_ready,
  output logic                 out_valid,
  output logic [SQ_W-1:0]      out_data,
  output logic                 out_last
);

  // The sum of two squares of signed parts fits SQ_W bits without a carry.
  function automatic logic [SQ_W-1:0] add_squares(input logic [SQ_W-1:0] a,
                                                   input logic [SQ_W-1:0] b);
    return a + b;
  endfunction

  logic load;

  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)        out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      out_data <= add_squares(sq_pair[1], sq_pair[0]);
      out_last <= in_last;
    end
  end

endmodule

// File: rtl/cplx_magsq_stream.sv
module cplx_magsq_stream #(
  parameter int unsigned PART_W = magsq_pkg::MSQ_PART_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*PART_W-1:0]   s_tdata,
  input  logic                  s_tvalid,
  input  logic                  s_tlast,
  output logic                  s_tready,
  output logic [2*PART_W-1:0]   m_tdata,
  output logic                  m_tvalid,
  output logic                  m_tlast,
  output logic [PART_W/4-1:0]   m_tstrb,
  input  logic                  m_tready
);

  localparam int unsigned DATA_W = 2 * PART_W;
  localparam int unsigned SQ_W   = magsq_pkg::msq_res_w(PART_W);

  logic                 sq_valid;
  logic                 sq_last;
  logic [1:0][SQ_W-1:0] sq_pair;
  logic                 sum_ready;

  // Named handshake events, observed by the bound checker.
  logic s_fire;
  logic m_fire;

  assign s_fire  = s_tvalid && s_tready;
  assign m_fire  = m_tvalid && m_tready;
  assign m_tstrb = '1;

  magsq_square_stage #(.PART_W(PART_W)) u_square (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (s_tvalid),
    .in_data  (s_tdata),
    .in_last  (s_tlast),
    .dn_ready (sum_ready),
    .in_ready (s_tready),
    .out_valid(sq_valid),
    .out_last (sq_last),
    .sq_pair  (sq_pair)
  );

  magsq_sum_stage #(.SQ_W(SQ_W)) u_sum (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (sq_valid),
    .sq_pair  (sq_pair),
    .in_last  (sq_last),
    .out_ready(m_tready),
    .in_ready (sum_ready),
    .out_valid(m_tvalid),
    .out_data (m_tdata),
    .out_last (m_tlast)
  );

endmodule

// File: rtl/magsq_checker.sv
module magsq_checker #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_tready,
  input logic              s_fire,
  input logic              m_tvalid,
  input logic              m_tready,
  input logic              m_fire,
  input logic              m_tlast,
  input logic [DATA_W-1:0] m_tdata,
  input logic [DATA_W/8-1:0] m_tstrb
);

  localparam logic [DATA_W-1:0] MAX_RES = {1'b1, {(DATA_W-1){1'b0}}};

  // Beats accepted but not yet delivered.
  logic [2:0] inflight;

  always_ff @(posedge clk) begin
    if (!rst_n) inflight <= '0;
    else begin
      case ({s_fire, m_fire})
        2'b10:   inflight <= inflight + 3'd1;
        2'b01:   inflight <= inflight - 3'd1;
        default: inflight <= inflight;
      endcase
    end
  end

  p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> (m_tdata <= MAX_RES));

  p_depth_r4: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 3'd2);

  p_no_phantom_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight == 3'd0) |-> !m_tvalid);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

  p_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !m_tvalid |-> s_tready);

  p_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !s_tready |-> (m_tvalid && !m_tready));

  p_strb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> (m_tstrb == '1));

  p_reset_r9: assert property (@(posedge clk)
    !rst_n |=> !m_tvalid);

endmodule

bind cplx_magsq_stream magsq_checker #(.DATA_W(DATA_W)) u_magsq_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .s_tready(s_tready),
  .s_fire  (s_fire),
  .m_tvalid(m_tvalid),
  .m_tready(m_tready),
  .m_fire  (m_fire),
  .m_tlast (m_tlast),
  .m_tdata (m_tdata),
  .m_tstrb (m_tstrb)
);

// File: tb/tb_cplx_magsq_stream.sv
module tb_cplx_magsq_stream;

  localparam int CLK_PERIOD = 10;
  localparam int PART_W     = 16;

  logic        clk;
  logic        rst_n;
  logic [31:0] s_tdata;
  logic        s_tvalid;
  logic        s_tlast;
  logic        s_tready;
  logic [31:0] m_tdata;
  logic        m_tvalid;
  logic        m_tlast;
  logic [3:0]  m_tstrb;
  logic        m_tready;

  cplx_magsq_stream #(.PART_W(PART_W)) dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_tdata (s_tdata),
    .s_tvalid(s_tvalid),
    .s_tlast (s_tlast),
    .s_tready(s_tready),
    .m_tdata (m_tdata),
    .m_tvalid(m_tvalid),
    .m_tlast (m_tlast),
    .m_tstrb (m_tstrb),
    .m_tready(m_tready)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int n_in     = 0;
  int n_out    = 0;
  int beat_idx = 0;
  bit in_h_prev = 0;
  bit prev_stall = 0;
  logic [31:0] prev_data;
  logic        prev_last;
  logic [31:0] exp_data_q[$];
  bit          exp_last_q[$];

  logic [31:0] dir_words[8] = '{32'h8000_8000, 32'h7FFF_8000, 32'hFFFF_0000,
                                32'h0000_0000, 32'hFFFD_0004, 32'h0001_FFFF,
                                32'h7FFF_7FFF, 32'h0000_8000};

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Independent model: signed halves, integer arithmetic.
  function automatic logic [31:0] ref_magsq(input logic [31:0] w);
    longint re, im;
    re = longint'($signed(w[31:16]));
    im = longint'($signed(w[15:0]));
    return 32'(re * re + im * im);
  endfunction

  function automatic logic [31:0] next_word();
    if (beat_idx < 8) return dir_words[beat_idx];
    return $urandom;
  endfunction

  // One cycle: drive at the falling edge, observe 1 ns later.
  task automatic step(input int vpct, input int rmode);
    bit in_h, out_h;
    @(negedge clk);
    if (!s_tvalid || in_h_prev) begin
      if (int'($urandom_range(99)) < vpct) begin
        s_tdata  = next_word();
        s_tlast  = (beat_idx % 8 == 7);
        s_tvalid = 1'b1;
        beat_idx++;
      end else begin
        s_tvalid = 1'b0;
      end
    end
    case (rmode)
      0:       m_tready = 1'b1;
      1:       m_tready = 1'b0;
      default: m_tready = 1'($urandom_range(1));
    endcase
    #1;
    // R6: blocked only when two beats are held and the output stalls
    chk(s_tready == !(exp_data_q.size() == 2 && !m_tready), "R6 s_tready",
        s_tready, !(exp_data_q.size() == 2 && !m_tready));
    if (prev_stall) begin
      chk(m_tvalid && m_tdata == prev_data && m_tlast == prev_last, "R5 hold",
          {m_tvalid, m_tdata}, {1'b1, prev_data});
    end
    in_h  = s_tvalid && s_tready;
    out_h = m_tvalid && m_tready;
    if (out_h) begin
      if (exp_data_q.size() == 0) begin
        chk(1'b0, "R4 unexpected output", m_tdata, 0);
      end else begin
        logic [31:0] ed;
        bit el;
        ed = exp_data_q.pop_front();
        el = exp_last_q.pop_front();
        chk(m_tdata == ed, "R1,R2 data", m_tdata, ed);
        chk(m_tlast == el, "R3 last", m_tlast, el);
      end
      n_out++;
    end
    if (in_h) begin
      exp_data_q.push_back(ref_magsq(s_tdata));
      exp_last_q.push_back(s_tlast);
      n_in++;
    end
    in_h_prev  = in_h;
    prev_stall = m_tvalid && !m_tready;
    prev_data  = m_tdata;
    prev_last  = m_tlast;
  endtask

  task automatic run(input int cycles, input int vpct, input int rmode);
    for (int i = 0; i < cycles; i++) step(vpct, rmode);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL R4 watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    s_tvalid = 1'b1;
    s_tdata  = 32'h1234_5678;
    s_tlast  = 1'b0;
    m_tready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(m_tvalid == 1'b0, "R9 valid low in reset", m_tvalid, 0);
    chk(m_tstrb == 4'hF, "R8 strobes", m_tstrb, 4'hF);
    @(negedge clk);
    s_tvalid = 1'b0;
    rst_n    = 1'b1;
    #1;
    chk(m_tvalid == 1'b0, "R9 valid low after release", m_tvalid, 0);

    // R7 latency with the worst-case operand (R2 literal)
    @(negedge clk);
    s_tdata  = 32'h8000_8000;
    s_tlast  = 1'b1;
    s_tvalid = 1'b1;
    #1;
    chk(s_tready == 1'b1, "R6 ready when empty", s_tready, 1);
    @(negedge clk);
    s_tvalid = 1'b0;
    #1;
    chk(m_tvalid == 1'b0, "R7 not yet valid", m_tvalid, 0);
    @(negedge clk);
    #1;
    chk(m_tvalid == 1'b1, "R7 valid after two edges", m_tvalid, 1);
    chk(m_tdata == 32'h8000_0000, "R2 max result", m_tdata, 32'h8000_0000);
    chk(m_tlast == 1'b1, "R3 last carried", m_tlast, 1);
    chk(m_tstrb == 4'hF, "R8 strobes on beat", m_tstrb, 4'hF);
    @(negedge clk);
    #1;
    chk(m_tvalid == 1'b0, "R4 no repeat", m_tvalid, 0);

    run(200, 100, 0);
    run(150, 80, 2);
    run(320, 100, 1);
    chk(s_tready == 1'b0, "R6 blocked on long stall", s_tready, 0);
    run(40, 100, 0);
    run(20, 100, 1);
    run(300, 70, 2);

    // Reset with the pipeline full (R9)
    run(10, 100, 1);
    @(negedge clk);
    rst_n    = 1'b0;
    s_tvalid = 1'b1;
    m_tready = 1'b0;
    @(negedge clk);
    #1;
    chk(m_tvalid == 1'b0, "R9 reset flushes", m_tvalid, 0);
    s_tvalid = 1'b0;
    rst_n    = 1'b1;
    exp_data_q.delete();
    exp_last_q.delete();
    n_in = 0;
    n_out = 0;
    in_h_prev  = 0;
    prev_stall = 0;
    #1;
    chk(m_tvalid == 1'b0, "R9 empty after reset", m_tvalid, 0);

    run(200, 90, 2);
    run(30, 0, 0);
    chk(n_in == n_out, "R4 transfer count", n_out, n_in);
    chk(exp_data_q.size() == 0, "R4 nothing pending", exp_data_q.size(), 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule